// File: doc/BRIEF.md
# Start-Gated Self-Halting Decade Counter

This block is a synchronous single-digit BCD counter whose run is gated by a level input. While the run input is low, the digit is held at zero. Once the run input goes high, the digit counts up by one on each rising clock edge. It stops at nine and stays there while the run input remains high. The counter never wraps back to zero by itself. Lowering the run input returns it to zero, ready for the next run.

Typical use is a fixed-length sequencer or a timeout stage. The caller raises the run input, and the done flag marks the point at which the full count of ten states has been covered. The digit width and terminal value are parameters. A parameter also chooses whether the done flag is decoded from the count or kept in a flop of its own.

Top module: `sstop_decade_counter`

## Requirements
- R1: A high `rst` at a rising edge loads count 0 and done 0, whatever `start` is; reset has priority over `start`.
- R2: With `rst` low and `start` low at a rising edge, the count becomes 0 at that edge, from any state.
- R3: With `rst` low, `start` high and a count below nine, each rising edge raises the count by exactly one. A run begins at 0, so the count goes 0, 1, 2 and so on.
- R4: With `rst` low, `start` high and a count of nine (binary 1001), the count stays at nine on every later edge.
- R5: `done` is 1 exactly when the count is nine, and 0 for every other count.
- R6: The count is always a legal BCD code 0..9. If the state ever holds a code from 10 to 15, it goes to 0 on the next edge.
- R7: A run cut short by a low `start` and then restarted counts again from 0, not from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run level: high counts, low clears |
| count | output | 4 | Current BCD digit (WIDTH bits) |
| done | output | 1 | High while the digit sits at the terminal value |

## Verification
Two kinds of fault in the state register are easy to see at the ports. If the register wraps or skips a step, `count` shows it on the very edge after the faulty step, because the bench predicts every value from the run length. If the register fails to clear, the digit is nonzero one edge after `start` drops. A done flag that is decoded wrong or lags by a cycle disagrees with the count on the first cycle at or after nine. Run lengths from 0 to 14 edges are swept. Runs are cut short and restarted, and reset is applied in the middle of a run.

// File: rtl/sstop_pkg.sv
package sstop_pkg;
   // Action chosen for the next clock edge
   typedef enum logic [1:0] {
      ACT_CLEAR = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_HOLD  = 2'd2
   } sstop_act_e;
endpackage

// File: rtl/sstop_ctrl.sv
module sstop_ctrl
   import sstop_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int TERMINAL = 9
) (
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] cur,
   output sstop_act_e       act
);
   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);

   always_comb begin
      if (rst || !start || (cur > TERM_V)) begin
         act = ACT_CLEAR;
      end else if (cur == TERM_V) begin
         act = ACT_HOLD;
      end else begin
         act = ACT_STEP;
      end
   end
endmodule

// File: rtl/sstop_step.sv
module sstop_step
   import sstop_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  sstop_act_e       act,
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   always_comb begin
      unique case (act)
         ACT_STEP: nxt = cur + WIDTH'(1);
         ACT_HOLD: nxt = cur;
         default:  nxt = '0;
      endcase
   end
endmodule

// File: rtl/sstop_flag.sv
module sstop_flag #(
   parameter int WIDTH    = 4,
   parameter int TERMINAL = 9,
   parameter bit REG_DONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] nxt,
   output logic             flag
);
   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);

   generate
      if (REG_DONE) begin : g_reg
         logic flag_r;
         always_ff @(posedge clk) begin
            if (rst) flag_r <= 1'b0;
            else     flag_r <= (nxt == TERM_V);
         end
         assign flag = flag_r;
      end else begin : g_comb
         assign flag = (cur == TERM_V);
      end
   endgenerate
endmodule

// File: rtl/sstop_decade_counter.sv
module sstop_decade_counter
   import sstop_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int TERMINAL = 9,
   parameter bit REG_DONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic [WIDTH-1:0] count,
   output logic             done
);
   generate
      if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
         $error("sstop_decade_counter: WIDTH out of range");
      end
      if (TERMINAL < 1 || TERMINAL >= (1 << WIDTH)) begin : g_bad_term
         $error("sstop_decade_counter: TERMINAL does not fit WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   sstop_act_e       act;

   sstop_ctrl #(.WIDTH(WIDTH), .TERMINAL(TERMINAL)) u_ctrl (
      .rst   (rst),
      .start (start),
      .cur   (cnt_q),
      .act   (act)
   );

   sstop_step #(.WIDTH(WIDTH)) u_step (
      .act (act),
      .cur (cnt_q),
      .nxt (cnt_d)
   );

   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   sstop_flag #(.WIDTH(WIDTH), .TERMINAL(TERMINAL), .REG_DONE(REG_DONE)) u_flag (
      .clk  (clk),
      .rst  (rst),
      .cur  (cnt_q),
      .nxt  (cnt_d),
      .flag (done)
   );

   assign count = cnt_q;
endmodule

// File: rtl/sstop_decade_counter_chk.sv
module sstop_decade_counter_chk #(
   parameter int WIDTH    = 4,
   parameter int TERMINAL = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [WIDTH-1:0] count,
   input logic             done
);
   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);

   logic seen_edge = 1'b0;
   always_ff @(posedge clk) seen_edge <= 1'b1;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      (seen_edge && $past(rst)) |-> (count == '0 && !done));

   // R2
   start_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> (count == '0));

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      (start && count < TERM_V) |=> (count == $past(count) + WIDTH'(1)));

   // R4
   halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (start && count == TERM_V) |=> (count == TERM_V));

   // R5
   done_match_chk: assert property (@(posedge clk) disable iff (rst)
      done == (count == TERM_V));

   // R6
   legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      count <= TERM_V);
endmodule

bind sstop_decade_counter sstop_decade_counter_chk #(
   .WIDTH(WIDTH), .TERMINAL(TERMINAL)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .start (start),
   .count (count),
   .done  (done)
);

// File: tb/sstop_decade_counter_tb.sv
module sstop_decade_counter_tb;
   localparam int W = 4;
   localparam int T = 9;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] count;
   logic         done;

   int vecs = 0;
   int errs = 0;
   int exp_cnt = 0;
   int prev_exp = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sstop_decade_counter #(.WIDTH(W), .TERMINAL(T), .REG_DONE(1'b1)) u_dut (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .count (count),
      .done  (done)
   );

   task automatic check(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Apply one cycle of inputs, update the arithmetic model, compare after the edge
   task automatic cyc(input bit r, input bit s, input bit restart);
      string tag;
      @(negedge clk);
      rst = r;
      start = s;
      @(posedge clk);
      #1;
      prev_exp = exp_cnt;
      if (r)            begin exp_cnt = 0; tag = "R1"; end
      else if (!s)      begin exp_cnt = 0; tag = "R2"; end
      else if (exp_cnt < T) begin
         exp_cnt = exp_cnt + 1;
         tag = restart ? "R7" : "R3";
      end else          begin tag = "R4"; end
      check(tag, int'(count), exp_cnt);
      check("R5", int'(done), (exp_cnt == T) ? 1 : 0);
      check("R6", (int'(count) <= T) ? 1 : 0, 1);
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      int lfsr;
      // R1: reset state
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      // Sweep run lengths 0..14, each followed by a clearing cycle (R2, R3, R4)
      for (int len = 0; len <= 14; len++) begin
         for (int k = 0; k < len; k++) cyc(1'b0, 1'b1, 1'b0);
         cyc(1'b0, 1'b0, 1'b0);
      end
      // R7: cut a run at 5, restart from 0
      for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 11; k++) cyc(1'b0, 1'b1, 1'b0);
      // R1: reset while running and at terminal, start held high
      cyc(1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 1'b1);
      // Pseudo-random start/reset pattern
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         bit b0;
         b0 = lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5];
         lfsr = {16'd0, b0, lfsr[15:1]};
         cyc((lfsr[7:0] == 8'h3C), (lfsr[3:0] != 4'h0), 1'b0);
      end
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule